// File: doc/BRIEF.md
# Snooping Translation Buffer with Broadcast Invalidate

This block is a small fully associative translation buffer. It turns a virtual address, split into a page number and an offset, into a physical address made of a frame number and the same offset. Its processor fills entries through a refill port after a walk of the page table, which is done outside the block.

The buffer sits on a shared bus. When any agent changes a page-table entry, it broadcasts that page number on the bus. Every buffer watches the bus and drops its own matching entries. The processor that owns the buffer is never interrupted. When the local processor has changed an entry, it asks the block to broadcast. The block then requests the bus and waits for the grant. At the grant it drops its own copy and drives the page for one cycle. Bus arbitration decides which of two competing changes is seen first.

Top module: `snoop_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` high gives `lk_done` high on the next cycle. If a valid entry holds the page in the upper bits of `lk_vaddr`, `lk_hit` is 1 and `lk_paddr` is that entry's frame number concatenated above the OFF_W-bit offset, which is copied unchanged.
- R2: After reset every entry is invalid and all outputs are 0. A lookup that finds no valid entry gives `lk_hit` = 0 and `lk_paddr` = 0. `lk_done` is 0 in any cycle that follows one with no request.
- R3: A refill (`rf_valid`) takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the old contents, and a lookup in any later cycle sees the new entry.
- R4: `snoop_valid` clears, at that edge, every valid entry whose page equals `snoop_page`. No other entry changes.
- R5: A refill picks its slot in this order:
  - the entry that already holds the same page, which it overwrites;
  - otherwise the lowest-numbered invalid entry;
  - otherwise the entry under a round-robin pointer.
  The pointer starts at 0 after reset. It advances by one, wrapping after ENTRIES-1, only on refills that use it.
- R6: If a refill coincides with a snoop invalidate or a local broadcast of the same page, the refilled entry is left invalid.
- R7: An `inv_req` while the broadcast unit is idle captures `inv_page`. `bus_req` is then high from the next cycle through the first cycle in which `bus_grant` is high.
- R8: In the grant cycle, local entries matching the captured page are cleared at that edge. On the next cycle `bc_valid` is high for exactly one cycle with `bc_page` equal to the captured page, and `bus_req` is low.
- R9: An `inv_req` that arrives while a broadcast is pending or being driven is ignored. The page on the bus stays the first one captured, and the later page's entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | PAGE_W+OFF_W | Virtual address to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_paddr | output | FRAME_W+OFF_W | Translated physical address, 0 on miss |
| rf_valid | input | 1 | Refill write strobe |
| rf_page | input | PAGE_W | Page number being refilled |
| rf_frame | input | FRAME_W | Frame number for the refilled page |
| inv_req | input | 1 | Local request to broadcast an invalidate |
| inv_page | input | PAGE_W | Page to broadcast |
| bus_req | output | 1 | Shared bus request |
| bus_grant | input | 1 | Shared bus grant |
| bc_valid | output | 1 | Broadcast driven on the bus this cycle |
| bc_page | output | PAGE_W | Page number being broadcast |
| snoop_valid | input | 1 | Invalidate broadcast seen on the bus |
| snoop_page | input | PAGE_W | Page number of the snooped broadcast |

## Verification
The bench drives every input just after a falling edge and reads every output at the next falling edge. Each result is therefore checked one register stage after its stimulus:
- lookup results on the cycle after the request;
- `bus_req` on the cycle after `inv_req` is accepted;
- `bc_valid` and `bc_page` on the cycle after the grant.

A table clear or a refill is checked with a lookup issued in the cycle after it. The bench's own reference model is advanced on each rising edge from the inputs held during that cycle, so its expectation for a given cycle is ready before the falling edge at which it is compared.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    BC_IDLE  = 2'd0,
    BC_WAIT  = 2'd1,
    BC_DRIVE = 2'd2
  } bc_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic [PAGE_W-1:0]  rf_page,
  output logic [ENTRIES-1:0] rf_match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               kill_a_en,
  input  logic [PAGE_W-1:0]  kill_a_page,
  input  logic               kill_b_en,
  input  logic [PAGE_W-1:0]  kill_b_page,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame
);
  logic               vld_q   [ENTRIES];
  logic [PAGE_W-1:0]  tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    logic killed;
    assign sel    = wr_en && (wr_idx == IDX_W'(e));
    assign killed = (kill_a_en && tag_q[e] == kill_a_page) ||
                    (kill_b_en && tag_q[e] == kill_b_page);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[e] <= 1'b0;
      end else begin
        if (killed) vld_q[e] <= 1'b0;
        if (sel)    vld_q[e] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e]   <= wr_page;
        frame_q[e] <= wr_frame;
      end
    end

    // R4
    snoop_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (kill_a_en && vld_q[e] && tag_q[e] == kill_a_page && !sel) |=> !vld_q[e]);
  end

  always_comb begin
    lk_frame = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      valid_vec[e]    = vld_q[e];
      lk_hit_vec[e]   = vld_q[e] && (tag_q[e] == lk_page);
      rf_match_vec[e] = vld_q[e] && (tag_q[e] == rf_page);
      if (lk_hit_vec[e]) lk_frame = lk_frame | frame_q[e];
    end
  end

  // R5
  unique_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] match_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic             any_match, any_free, use_rr;
  logic [IDX_W-1:0] match_idx, free_idx, rr_q;

  always_comb begin
    any_match = 1'b0;
    any_free  = 1'b0;
    match_idx = '0;
    free_idx  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) begin
        any_match = 1'b1;
        match_idx = IDX_W'(e);
      end
      if (!valid_vec[e]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(e);
      end
    end
    use_rr     = !any_match && !any_free;
    victim_idx = any_match ? match_idx : (any_free ? free_idx : rr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fire && use_rr)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R5
  free_pref_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !any_match && any_free) |-> !valid_vec[victim_idx]);
  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && any_match) |-> match_vec[victim_idx]);
  // R5
  rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fire && use_rr) |=> $stable(rr_q));
endmodule

// File: rtl/tlb_bcast.sv
module tlb_bcast
  import tlb_pkg::*;
#(
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_req,
  input  logic [PAGE_W-1:0] inv_page,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              bc_valid,
  output logic [PAGE_W-1:0] bc_page,
  output logic              kill_en,
  output logic [PAGE_W-1:0] kill_page
);
  bc_state_e         state_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BC_IDLE;
      page_q  <= '0;
    end else begin
      case (state_q)
        BC_IDLE: if (inv_req) begin
          state_q <= BC_WAIT;
          page_q  <= inv_page;
        end
        BC_WAIT:  if (bus_grant) state_q <= BC_DRIVE;
        BC_DRIVE: state_q <= BC_IDLE;
        default:  state_q <= BC_IDLE;
      endcase
    end
  end

  assign bus_req   = (state_q == BC_WAIT);
  assign bc_valid  = (state_q == BC_DRIVE);
  assign bc_page   = bc_valid ? page_q : '0;
  assign kill_en   = bus_req && bus_grant;
  assign kill_page = page_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_grant) |=> bus_req);
  // R8
  bc_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> $past(bus_req && bus_grant));
  // R8
  bc_single_chk: assert property (@(posedge clk) disable iff (rst)
    bc_valid |=> !bc_valid);
  // R9
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> $stable(page_q));
endmodule

// File: rtl/snoop_tlb.sv
module snoop_tlb #(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  output logic               lk_done,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_paddr,
  input  logic               rf_valid,
  input  logic [PAGE_W-1:0]  rf_page,
  input  logic [FRAME_W-1:0] rf_frame,
  input  logic               inv_req,
  input  logic [PAGE_W-1:0]  inv_page,
  output logic               bus_req,
  input  logic               bus_grant,
  output logic               bc_valid,
  output logic [PAGE_W-1:0]  bc_page,
  input  logic               snoop_valid,
  input  logic [PAGE_W-1:0]  snoop_page
);
  logic [ENTRIES-1:0] lk_hit_vec, rf_match_vec, valid_vec;
  logic [FRAME_W-1:0] lk_frame;
  logic [IDX_W-1:0]   victim_idx;
  logic               kill_en, rf_keep;
  logic [PAGE_W-1:0]  kill_page;
  logic [PAGE_W-1:0]  lk_page;
  logic [OFF_W-1:0]   lk_off;

  assign lk_page = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off  = lk_vaddr[OFF_W-1:0];
  assign rf_keep = !((snoop_valid && snoop_page == rf_page) ||
                     (kill_en && kill_page == rf_page));

  tlb_cam #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) i_cam (
    .clk(clk), .rst(rst),
    .lk_page(lk_page), .lk_hit_vec(lk_hit_vec), .lk_frame(lk_frame),
    .rf_page(rf_page), .rf_match_vec(rf_match_vec), .valid_vec(valid_vec),
    .kill_a_en(snoop_valid), .kill_a_page(snoop_page),
    .kill_b_en(kill_en), .kill_b_page(kill_page),
    .wr_en(rf_valid), .wr_idx(victim_idx), .wr_valid(rf_keep),
    .wr_page(rf_page), .wr_frame(rf_frame)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk(clk), .rst(rst), .fire(rf_valid),
    .valid_vec(valid_vec), .match_vec(rf_match_vec), .victim_idx(victim_idx)
  );

  tlb_bcast #(.PAGE_W(PAGE_W)) i_bcast (
    .clk(clk), .rst(rst), .inv_req(inv_req), .inv_page(inv_page),
    .bus_grant(bus_grant), .bus_req(bus_req), .bc_valid(bc_valid),
    .bc_page(bc_page), .kill_en(kill_en), .kill_page(kill_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_done  <= lk_valid;
      lk_hit   <= lk_valid && (|lk_hit_vec);
      lk_paddr <= (lk_valid && (|lk_hit_vec)) ? {lk_frame, lk_off} : '0;
    end
  end

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> (lk_paddr == '0));
  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (|lk_hit_vec)) |=> (lk_paddr[OFF_W-1:0] == $past(lk_off)));
  // R6
  refill_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && snoop_valid && snoop_page == rf_page) |=> !valid_vec[$past(victim_idx)]);
endmodule

// File: tb/test_snoop_tlb.sv
module test_snoop_tlb;
  localparam int E  = 4;
  localparam int PW = 8;
  localparam int FW = 8;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, rf_valid = 0, inv_req = 0, bus_grant = 0, snoop_valid = 0;
  logic [PW+OW-1:0] lk_vaddr = '0;
  logic [PW-1:0] rf_page = '0, inv_page = '0, snoop_page = '0, bc_page;
  logic [FW-1:0] rf_frame = '0;
  logic lk_done, lk_hit, bus_req, bc_valid;
  logic [FW+OW-1:0] lk_paddr;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit compare_on = 0;

  always #10 clk = ~clk;

  snoop_tlb #(.ENTRIES(E), .PAGE_W(PW), .FRAME_W(FW), .OFF_W(OW)) i_snoop_tlb (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_page(rf_page), .rf_frame(rf_frame),
    .inv_req(inv_req), .inv_page(inv_page), .bus_req(bus_req),
    .bus_grant(bus_grant), .bc_valid(bc_valid), .bc_page(bc_page),
    .snoop_valid(snoop_valid), .snoop_page(snoop_page)
  );

  // behavioural reference model
  bit m_vld [E];
  int m_pg  [E];
  int m_fr  [E];
  int m_rr, m_st, m_pend;
  bit e_done, e_hit, e_req, e_bc;
  int e_paddr, e_bcp;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < E; i++) m_vld[i] = 0;
      m_rr = 0; m_st = 0; m_pend = 0;
      e_done = 0; e_hit = 0; e_paddr = 0;
    end else begin
      automatic int pg = int'(lk_vaddr) >> OW;
      automatic bit grant = (m_st == 1) && bus_grant;
      automatic int slot = -1;
      e_done = lk_valid; e_hit = 0; e_paddr = 0;
      if (lk_valid)
        for (int i = 0; i < E; i++)
          if (m_vld[i] && m_pg[i] == pg) begin
            e_hit = 1;
            e_paddr = (m_fr[i] << OW) | (int'(lk_vaddr) & ((1 << OW) - 1));
          end
      if (rf_valid) begin
        for (int i = 0; i < E; i++)
          if (slot < 0 && m_vld[i] && m_pg[i] == int'(rf_page)) slot = i;
        for (int i = 0; i < E; i++)
          if (slot < 0 && !m_vld[i]) slot = i;
        if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % E; end
      end
      for (int i = 0; i < E; i++) begin
        if (snoop_valid && m_pg[i] == int'(snoop_page)) m_vld[i] = 0;
        if (grant && m_pg[i] == m_pend) m_vld[i] = 0;
      end
      if (slot >= 0) begin
        m_pg[slot] = int'(rf_page);
        m_fr[slot] = int'(rf_frame);
        m_vld[slot] = !((snoop_valid && snoop_page == rf_page) ||
                        (grant && m_pend == int'(rf_page)));
      end
      case (m_st)
        0: if (inv_req) begin m_st = 1; m_pend = int'(inv_page); end
        1: if (bus_grant) m_st = 2;
        default: m_st = 0;
      endcase
    end
    e_req = (m_st == 1);
    e_bc  = (m_st == 2);
    e_bcp = e_bc ? m_pend : 0;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      check("R1 model lk_done", int'(lk_done), int'(e_done));
      check("R1 model lk_hit", int'(lk_hit), int'(e_hit));
      check("R1 model lk_paddr", int'(lk_paddr), e_paddr);
      check("R7 model bus_req", int'(bus_req), int'(e_req));
      check("R8 model bc_valid", int'(bc_valid), int'(e_bc));
      check("R8 model bc_page", int'(bc_page), e_bcp);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic refill(int pg, int fr);
    rf_valid = 1; rf_page = PW'(pg); rf_frame = FW'(fr);
    step();
    rf_valid = 0;
  endtask

  task automatic look(string tag, int pg, int off, bit hit, int pa);
    lk_valid = 1; lk_vaddr = (PW + OW)'((pg << OW) | off);
    step();
    lk_valid = 0;
    check(tag, int'(lk_hit), int'(hit));
    check(tag, int'(lk_paddr), pa);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    compare_on = 1;
    step();
    // R2 reset state
    check("R2 reset lk_done", int'(lk_done), 0);
    check("R2 reset bus_req", int'(bus_req), 0);
    check("R2 reset bc_valid", int'(bc_valid), 0);
    look("R2 miss after reset", 5, 3, 0, 0);

    // R3 same-cycle lookup sees old contents
    rf_valid = 1; rf_page = 5; rf_frame = 8'h50;
    lk_valid = 1; lk_vaddr = 12'h05A;
    step();
    rf_valid = 0; lk_valid = 0;
    check("R3 same-cycle miss", int'(lk_hit), 0);
    look("R1 hit offset passes", 5, 4'hA, 1, 12'h50A);

    // R5 fill then round-robin replacement
    refill(6, 8'h60); refill(7, 8'h70); refill(8, 8'h80);
    refill(9, 8'h90);                        // replaces entry 0 (page 5)
    look("R5 rr victim 0", 5, 0, 0, 0);
    look("R5 others kept", 8, 1, 1, 12'h801);
    refill(10, 8'hA0);                       // replaces entry 1 (page 6)
    look("R5 rr victim 1", 6, 0, 0, 0);
    // R5 same page overwrites, pointer unchanged
    refill(7, 8'h77);
    look("R5 same-page overwrite", 7, 2, 1, 12'h772);
    refill(11, 8'hB0);                       // pointer still 2 -> entry 2
    look("R5 pointer not advanced", 7, 0, 0, 0);

    // R4 snoop invalidate
    snoop_valid = 1; snoop_page = 9;
    step();
    snoop_valid = 0;
    look("R4 snooped entry gone", 9, 0, 0, 0);
    look("R4 other entry kept", 10, 5, 1, 12'hA05);
    refill(12, 8'hC0);                       // invalid entry 0 preferred
    look("R5 free slot used", 8, 0, 1, 12'h800);
    refill(13, 8'hD0);                       // pointer 3 -> page 8 evicted
    look("R5 rr victim 3", 8, 0, 0, 0);
    look("R5 free slot holds", 12, 0, 1, 12'hC00);

    // R6 snoop coinciding with refill
    rf_valid = 1; rf_page = 14; rf_frame = 8'hE0;
    snoop_valid = 1; snoop_page = 14;
    step();
    rf_valid = 0; snoop_valid = 0;
    look("R6 refill killed by snoop", 14, 0, 0, 0);

    // R7 R9 R8 local broadcast
    inv_req = 1; inv_page = 10;
    step();
    inv_req = 0;
    check("R7 bus_req raised", int'(bus_req), 1);
    inv_req = 1; inv_page = 11;
    step();
    inv_req = 0;
    check("R7 bus_req held", int'(bus_req), 1);
    step();
    bus_grant = 1;
    step();
    bus_grant = 0;
    check("R8 bc_valid", int'(bc_valid), 1);
    check("R9 bc_page first page", int'(bc_page), 10);
    check("R8 bus_req dropped", int'(bus_req), 0);
    step();
    check("R8 single pulse", int'(bc_valid), 0);
    look("R8 local entry cleared", 10, 0, 0, 0);
    look("R9 ignored page kept", 11, 1, 1, 12'hB01);

    // R6 local broadcast coinciding with refill of same page
    inv_req = 1; inv_page = 13;
    step();
    inv_req = 0;
    bus_grant = 1; rf_valid = 1; rf_page = 13; rf_frame = 8'hDD;
    step();
    bus_grant = 0; rf_valid = 0;
    step();
    look("R6 refill killed by broadcast", 13, 0, 0, 0);
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule